// File: doc/BRIEF.md
# Programmable Up-Counter with Divided-Clock Source and Interrupt Mask

This block is a small program-controlled up-counter for a microcontroller core. It can advance from one of two sources. One is a free-running divider on the instruction clock. The other is the rising edge of an external input pin. A mode flip-flop selects the source.

Software can preload the count at any time, and doing so restarts the divider. When the count wraps from its top value to zero, the block emits an overflow strobe and keeps counting. A mask flip-flop decides whether that wrap is passed on as an interrupt request. A wrap that raises a request also sets the mask, so later wraps stay silent until software clears the mask. Software can read the mask at any time.

The interrupt controller and the instruction decoder sit outside this block. They drive the command strobes and consume `irq_req`.

Top module: `tmr_cnt_unit`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `count`, `mode_q`, `mask_q`, `irq_req` and `ovf_pulse` are all 0, and the divider is at 0.
- R2: With `mode_q`=0, the count advances by one on every 2**PRE_W-th clock edge after reset or after the last load. With PRE_W=6 this is the 64th edge. The divider never stops.
- R3: The count runs up to 2**CNT_W-1 (15 at default) and then returns to 0 and continues counting. `ovf_pulse` is 1 for exactly the one cycle in which `count` first shows 0 after such a wrap.
- R4: With `mode_q`=1, each rising edge of `ext_in` advances the count by one. The new value shows on the third clock edge after `ext_in` rises (two synchronizer stages plus one edge register). Falling edges have no effect.
- R5: `load_en`=1 writes `load_val` into the count on the next edge and clears the divider to 0. A load wins over an increment in the same cycle, and no overflow comes from that cycle.
- R6: A wrap while `mask_q`=0 makes `irq_req` 1 for one cycle, in the same cycle as `ovf_pulse`. On the same edge, `mask_q` becomes 1.
- R7: A wrap while `mask_q`=1 still gives `ovf_pulse`, but `irq_req` stays 0.
- R8: `mask_set` makes `mask_q` 1 and `mask_clr` makes it 0, each on the next edge. If both are high, set wins. A wrap that raises a request overrides `mask_clr`. `mask_q` is always visible as the test result.
- R9: `mode_set` makes `mode_q` 1 and `mode_clr` makes it 0, each on the next edge. If both are high, set wins.
- R10: With `mode_q`=0, toggling `ext_in` has no effect on `count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| ext_in | input | 1 | External event pin (asynchronous) |
| load_en | input | 1 | Load the count from `load_val` and clear the divider |
| load_val | input | CNT_W | Value to load |
| mode_set | input | 1 | Select external-edge source |
| mode_clr | input | 1 | Select divided-clock source |
| mask_set | input | 1 | Set the interrupt mask |
| mask_clr | input | 1 | Clear the interrupt mask |
| count | output | CNT_W | Current count |
| mode_q | output | 1 | Source select flip-flop |
| mask_q | output | 1 | Interrupt mask flip-flop (test readback) |
| irq_req | output | 1 | One-cycle interrupt request |
| ovf_pulse | output | 1 | One-cycle wrap strobe |

## Verification
The bench builds the block with its default parameters: CNT_W=4, PRE_W=6 and SYNC_STAGES=2. With these values the 64-cycle divider period and the three-edge latency of the pin path are checked at their real numbers. A full natural run from reset through a wrap takes 1024 cycles, which keeps the run short enough to cover several wraps. The scenarios cover both mask states at a wrap and a load that lands on the same edge as an external increment. They also cover simultaneous set and clear commands and pin activity while the divided-clock source is selected.

// File: rtl/tc_pkg.sv
package tc_pkg;
   typedef enum logic {
      TC_SRC_DIV = 1'b0,
      TC_SRC_PIN = 1'b1
   } tc_src_e;

   function automatic logic tc_setclr(input logic cur, input logic set, input logic clr);
      return set ? 1'b1 : (clr ? 1'b0 : cur);
   endfunction
endpackage

// File: rtl/tc_prescaler.sv
module tc_prescaler #(
   parameter int PRE_W = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   localparam logic [PRE_W-1:0] PRE_ONE = PRE_W'(1);

   logic [PRE_W-1:0] div_q;

   generate
      if (PRE_W < 1) begin : g_bad_w
         $error("tc_prescaler: PRE_W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)   div_q <= '0;
      else if (clr) div_q <= '0;
      else          div_q <= div_q + PRE_ONE;
   end

   assign tick = (&div_q) & ~clr;
endmodule

// File: rtl/tc_edge_sync.sv
module tc_edge_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise
);
   localparam int HIST = SYNC_STAGES + 1;

   logic [HIST-1:0] sh_q;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_depth
         $error("tc_edge_sync: SYNC_STAGES must be at least 2");
      end
      for (genvar i = 0; i < HIST; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) sh_q[i] <= 1'b0;
               else        sh_q[i] <= pin;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) sh_q[i] <= 1'b0;
               else        sh_q[i] <= sh_q[i-1];
            end
         end
      end
   endgenerate

   assign rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
endmodule

// File: rtl/tc_counter.sv
module tc_counter #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   generate
      if (CNT_W < 1) begin : g_bad_w
         $error("tc_counter: CNT_W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt_q <= '0;
      else if (load) cnt_q <= load_val;
      else if (inc)  cnt_q <= cnt_q + CNT_ONE;
   end

   assign wrap = inc & ~load & (cnt_q == CNT_MAX);
   assign cnt  = cnt_q;
endmodule

// File: rtl/tc_mask_ctl.sv
module tc_mask_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic wrap,
   input  logic set,
   input  logic clr,
   output logic mask,
   output logic irq,
   output logic ovf
);
   import tc_pkg::*;

   logic mask_q, irq_q, ovf_q, raise;

   assign raise = wrap & ~mask_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= 1'b0;
         irq_q  <= 1'b0;
         ovf_q  <= 1'b0;
      end else begin
         mask_q <= tc_setclr(mask_q, set | raise, clr);
         irq_q  <= raise;
         ovf_q  <= wrap;
      end
   end

   assign mask = mask_q;
   assign irq  = irq_q;
   assign ovf  = ovf_q;
endmodule

// File: rtl/tmr_cnt_unit.sv
module tmr_cnt_unit #(
   parameter int CNT_W       = 4,
   parameter int PRE_W       = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_in,
   input  logic             load_en,
   input  logic [CNT_W-1:0] load_val,
   input  logic             mode_set,
   input  logic             mode_clr,
   input  logic             mask_set,
   input  logic             mask_clr,
   output logic [CNT_W-1:0] count,
   output logic             mode_q,
   output logic             mask_q,
   output logic             irq_req,
   output logic             ovf_pulse
);
   import tc_pkg::*;

   tc_src_e src_q;
   logic    div_tick, pin_rise, step, wrap;

   always_ff @(posedge clk) begin
      if (!rst_n) src_q <= TC_SRC_DIV;
      else        src_q <= tc_src_e'(tc_setclr(src_q, mode_set, mode_clr));
   end

   assign mode_q = (src_q == TC_SRC_PIN);
   assign step   = (src_q == TC_SRC_PIN) ? pin_rise : div_tick;

   tc_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .clr(load_en), .tick(div_tick)
   );

   tc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin(ext_in), .rise(pin_rise)
   );

   tc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(load_en), .load_val(load_val),
      .inc(step), .cnt(count), .wrap(wrap)
   );

   tc_mask_ctl u_mask (
      .clk(clk), .rst_n(rst_n), .wrap(wrap), .set(mask_set), .clr(mask_clr),
      .mask(mask_q), .irq(irq_req), .ovf(ovf_pulse)
   );
endmodule

// File: rtl/tmr_cnt_chk.sv
module tmr_cnt_chk #(
   parameter int CNT_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             load_en,
   input logic [CNT_W-1:0] load_val,
   input logic             mode_set,
   input logic             mask_set,
   input logic [CNT_W-1:0] count,
   input logic             mode_q,
   input logic             mask_q,
   input logic             irq_req,
   input logic             ovf_pulse
);
   localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);

   p_ovf_at_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse |-> (count == '0));

   p_step_by_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(load_en) && count != $past(count)) |-> (count == $past(count) + C_ONE));

   p_load_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> (count == $past(load_val)));

   p_irq_unmasked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (!$past(mask_q) && mask_q));

   p_irq_with_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> ovf_pulse);

   p_mask_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mask_set |=> mask_q);

   p_mode_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mode_set |=> mode_q);
endmodule

bind tmr_cnt_unit tmr_cnt_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_val(load_val),
   .mode_set(mode_set), .mask_set(mask_set), .count(count), .mode_q(mode_q),
   .mask_q(mask_q), .irq_req(irq_req), .ovf_pulse(ovf_pulse)
);

// File: tb/tmr_cnt_unit_tb_top.sv
module tmr_cnt_unit_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int CW   = 4;
   localparam int PW   = 6;
   localparam int CMAX = (1 << CW) - 1;
   localparam int PMAX = (1 << PW) - 1;

   logic clk = 1'b0, rst_n = 1'b0, ext_in = 1'b0, load_en = 1'b0;
   logic [CW-1:0] load_val = '0;
   logic mode_set = 1'b0, mode_clr = 1'b0, mask_set = 1'b0, mask_clr = 1'b0;
   logic [CW-1:0] count;
   logic mode_q, mask_q, irq_req, ovf_pulse;

   int checks = 0, failures = 0, cycles = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tmr_cnt_unit dut_i (
      .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .load_en(load_en), .load_val(load_val),
      .mode_set(mode_set), .mode_clr(mode_clr), .mask_set(mask_set), .mask_clr(mask_clr),
      .count(count), .mode_q(mode_q), .mask_q(mask_q), .irq_req(irq_req), .ovf_pulse(ovf_pulse)
   );

   // Behavioural reference model
   int m_cnt = 0, m_pre = 0, m_mode = 0, m_mask = 0, m_irq = 0, m_ovf = 0;
   int hist[$] = '{0, 0, 0};

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_pre = 0; m_mode = 0; m_mask = 0; m_irq = 0; m_ovf = 0;
         hist = '{0, 0, 0};
      end else begin
         int tick, rise, inc, wrap;
         tick = (m_pre == PMAX && !load_en) ? 1 : 0;
         rise = (hist[1] == 1 && hist[2] == 0) ? 1 : 0;
         inc  = m_mode ? rise : tick;
         wrap = (inc && !load_en && m_cnt == CMAX) ? 1 : 0;
         m_irq = (wrap && !m_mask) ? 1 : 0;
         m_ovf = wrap;
         if (mask_set || m_irq) m_mask = 1;
         else if (mask_clr)     m_mask = 0;
         if (mode_set)      m_mode = 1;
         else if (mode_clr) m_mode = 0;
         if (load_en)  m_cnt = int'(load_val);
         else if (inc) m_cnt = (m_cnt + 1) % (CMAX + 1);
         m_pre = load_en ? 0 : (m_pre + 1) % (PMAX + 1);
         hist.push_front(int'(ext_in));
         void'(hist.pop_back());
      end
   end

   task automatic chk(input int act, input int exp, input string tag);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(int'(count),     m_cnt,  "R3 model count");
         chk(int'(ovf_pulse), m_ovf,  "R3 model ovf_pulse");
         chk(int'(irq_req),   m_irq,  "R6 model irq_req");
         chk(int'(mask_q),    m_mask, "R8 model mask_q");
         chk(int'(mode_q),    m_mode, "R9 model mode_q");
      end
   end

   task automatic finish_run();
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
         finish_run();
      end
   end

   task automatic do_load(input int v);
      @(negedge clk); load_en = 1'b1; load_val = CW'(v);
      @(negedge clk); load_en = 1'b0;
   endtask

   task automatic pin_pulse();
      @(negedge clk); ext_in = 1'b1;
      @(negedge clk); @(negedge clk); ext_in = 1'b0;
      @(negedge clk); @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(int'(count), 0, "R1 count in reset");
      chk(int'(irq_req) + int'(ovf_pulse) + int'(mask_q) + int'(mode_q), 0, "R1 flags in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk(int'(count), 0, "R1 count after release");
      repeat (62) @(negedge clk);
      chk(int'(count), 0, "R2 count before 64th edge");
      @(negedge clk);
      chk(int'(count), 1, "R2 count at 64th edge");

      // R10: pin activity in divided-clock mode
      repeat (4) pin_pulse();
      chk(int'(count), 1, "R10 pin ignored in timer mode");

      // R5 + R2: load clears divider; R6 wrap with mask clear
      do_load(15);
      chk(int'(count), 15, "R5 load value");
      repeat (63) @(negedge clk);
      chk(int'(count), 15, "R5 divider restarted by load");
      @(negedge clk);
      chk(int'(count), 0, "R3 wrap to zero");
      chk(int'(ovf_pulse), 1, "R3 ovf strobe");
      chk(int'(irq_req), 1, "R6 irq on unmasked wrap");
      chk(int'(mask_q), 1, "R6 mask set by wrap");
      @(negedge clk);
      chk(int'(irq_req), 0, "R6 irq one cycle");
      chk(int'(ovf_pulse), 0, "R3 ovf one cycle");

      // R7: masked wrap
      do_load(15);
      repeat (64) @(negedge clk);
      chk(int'(ovf_pulse), 1, "R7 ovf while masked");
      chk(int'(irq_req), 0, "R7 no irq while masked");

      // R8: mask commands
      @(negedge clk); mask_clr = 1'b1;
      @(negedge clk); mask_clr = 1'b0;
      chk(int'(mask_q), 0, "R8 mask cleared");
      @(negedge clk); mask_clr = 1'b1; mask_set = 1'b1;
      @(negedge clk); mask_clr = 1'b0; mask_set = 1'b0;
      chk(int'(mask_q), 1, "R8 set wins over clear");
      @(negedge clk); mask_clr = 1'b1;
      @(negedge clk); mask_clr = 1'b0;

      // R9: mode commands
      @(negedge clk); mode_set = 1'b1; mode_clr = 1'b1;
      @(negedge clk); mode_set = 1'b0; mode_clr = 1'b0;
      chk(int'(mode_q), 1, "R9 mode set wins");

      // R4: pin edges advance count, third edge latency
      do_load(3);
      @(negedge clk); ext_in = 1'b1;
      @(negedge clk); @(negedge clk);
      chk(int'(count), 3, "R4 no step before third edge");
      @(negedge clk);
      chk(int'(count), 4, "R4 step on third edge");
      ext_in = 1'b0;
      repeat (4) @(negedge clk);
      chk(int'(count), 4, "R4 falling edge ignored");
      pin_pulse(); pin_pulse();
      chk(int'(count), 6, "R4 two more edges");

      // R5: load wins over same-cycle increment
      @(negedge clk); ext_in = 1'b1;
      @(negedge clk); @(negedge clk); load_en = 1'b1; load_val = CW'(9);
      @(negedge clk); load_en = 1'b0;
      chk(int'(count), 9, "R5 load priority over step");
      ext_in = 1'b0;
      repeat (3) @(negedge clk);
      chk(int'(count), 9, "R5 step lost to load");

      // R6 in pin mode: wrap from 15 with mask clear
      do_load(15);
      @(negedge clk); ext_in = 1'b1;
      @(negedge clk); @(negedge clk); @(negedge clk);
      chk(int'(irq_req), 1, "R6 irq on pin wrap");
      chk(int'(count), 0, "R3 pin wrap to zero");
      ext_in = 1'b0;
      repeat (3) @(negedge clk);

      // back to divided clock
      @(negedge clk); mode_clr = 1'b1;
      @(negedge clk); mode_clr = 1'b0;
      chk(int'(mode_q), 0, "R9 mode cleared");
      repeat (200) @(negedge clk);
      finish_run();
   end
endmodule